// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

This block keeps a set of 32-bit mailbox words that processor cores use to signal one another. Each core owns a fixed group of mailboxes. With the default parameters there are four cores with four mailboxes each, sixteen words in all. Mailbox number `core*BOXES_PER_CORE + j` is mailbox `j` of that core.

A sender never overwrites a word. It posts bits by writing to the set window, where every one in the write data is ORed into the word. The receiver reads the word through the clear window. It acknowledges by writing to the same address, where every one in the write data clears the matching bit. The set window is write-only and reads back as zero. For every mailbox the block drives a pending flag that is high while the word holds any nonzero bit. These flags form a vector ordered by mailbox index and go to the interrupt routing logic. Enabling and routing of those interrupts belong to a different block.

The register interface uses byte addresses on word boundaries. The two low address bits are ignored. A write is applied on the rising clock edge where `reg_we` is high. Read data is combinational from the address and the current contents.

Top module: `ipc_mailbox_bank`

## Requirements
- R1: The bank holds NUM_CORES*BOXES_PER_CORE mailboxes, 16 by default. The mailbox with index i is reached at set address 0x80+4*i and clear/read address 0xC0+4*i. Bit i of `mbx_pending` belongs to that mailbox.
- R2: A write to the set window (0x80 to 0xBF) ORs the write data into the addressed mailbox. Bits already set stay set.
- R3: A write to the clear window (0xC0 to 0xFF) clears each bit of the addressed mailbox where the write data holds a one. All other bits keep their value.
- R4: A read in the clear window returns the current contents of the addressed mailbox in the same cycle, with no wait state.
- R5: A read in the set window returns zero, whatever the mailbox contents are.
- R6: Bit i of `mbx_pending` is high exactly when mailbox i holds at least one nonzero bit.
- R7: While `rst_n` is low, all mailboxes are cleared to zero, so every pending flag is low.
- R8: Writes to addresses outside both windows change no mailbox and no flag. Reads at such addresses return zero.
- R9: New contents and pending flags appear only after the rising edge that accepts the write. A cycle with `reg_we` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (8) | Byte address of the access; bits [1:0] ignored |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | DATA_W (32) | Write data: bits to set or bits to clear |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| mbx_pending | output | NUM_CORES*BOXES_PER_CORE (16) | Per-mailbox nonzero flags, bit i for mailbox i |

## Verification
The hardest case to reach from the ports is a mailbox that is partly cleared. Its flag must stay high while some bits remain and drop only when the last bit goes. Clearing everything at once would not show this. The stimulus first posts overlapping bit patterns in two separate set writes. It then clears a subset of the bits, then the rest. It reads the word back through the clear window after each step. A second difficult point is the mapping from index to flag. Every mailbox is loaded with a distinct pattern and then emptied one at a time, and the whole flag vector is compared after each step. This catches any swapped or aliased index.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // Which address window an access falls into.
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_SET  = 2'd1,
      WIN_CLR  = 2'd2
   } mbx_win_e;

   // Byte-to-word shift of the register interface.
   localparam int unsigned WORD_SHIFT = 2;
   localparam int unsigned WORD_BYTES = 1 << WORD_SHIFT;

endpackage

// File: rtl/mbx_win_decode.sv
module mbx_win_decode
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_BOXES = 16,
   parameter int unsigned SET_BASE  = 32'h80,
   parameter int unsigned CLR_BASE  = 32'hC0,
   localparam int unsigned IDX_W    = (NUM_BOXES > 1) ? $clog2(NUM_BOXES) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output mbx_win_e          win,
   output logic [IDX_W-1:0]  idx
);

   localparam int unsigned WA_W     = ADDR_W - WORD_SHIFT;
   localparam int unsigned SET_WORD = SET_BASE / WORD_BYTES;
   localparam int unsigned CLR_WORD = CLR_BASE / WORD_BYTES;

   logic [WA_W-1:0] word_addr;
   int unsigned     wa_i;
   logic            unused_lsb;
   logic            in_set;
   logic            in_clr;

   assign word_addr  = addr[ADDR_W-1:WORD_SHIFT];
   assign unused_lsb = ^addr[WORD_SHIFT-1:0];
   assign wa_i       = 32'(word_addr);

   assign in_set = (wa_i >= SET_WORD) && (wa_i < SET_WORD + NUM_BOXES);
   assign in_clr = (wa_i >= CLR_WORD) && (wa_i < CLR_WORD + NUM_BOXES);

   always_comb begin
      win = WIN_NONE;
      idx = '0;
      if (in_set) begin
         win = WIN_SET;
         idx = IDX_W'(wa_i - SET_WORD);
      end else if (in_clr) begin
         win = WIN_CLR;
         idx = IDX_W'(wa_i - CLR_WORD);
      end
   end

endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
   parameter int unsigned DATA_W         = 32,
   // 0: flag reduced from the stored word; 1: flag kept in its own flop
   parameter bit          FLAG_FROM_NEXT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_stb,
   input  logic              clr_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] word_q,
   output logic              pend
);

   logic [DATA_W-1:0] word_d;

   always_comb begin
      word_d = word_q;
      if (set_stb) begin
         word_d = word_q | wdata;
      end else if (clr_stb) begin
         word_d = word_q & ~wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else begin
         word_q <= word_d;
      end
   end

   generate
      if (FLAG_FROM_NEXT) begin : g_flag_flop
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
            end else begin
               pend_q <= |word_d;
            end
         end
         assign pend = pend_q;
      end else begin : g_flag_reduce
         assign pend = |word_q;
      end
   endgenerate

endmodule

// File: rtl/mbx_read_sel.sv
module mbx_read_sel
   import mbx_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_BOXES = 16,
   localparam int unsigned IDX_W    = (NUM_BOXES > 1) ? $clog2(NUM_BOXES) : 1
) (
   input  logic [NUM_BOXES-1:0][DATA_W-1:0] words,
   input  mbx_win_e                         win,
   input  logic [IDX_W-1:0]                 idx,
   output logic [DATA_W-1:0]                rdata
);

   // AND-OR selection: only the clear window reads back contents.
   always_comb begin
      rdata = '0;
      for (int b = 0; b < NUM_BOXES; b++) begin
         if ((win == WIN_CLR) && (idx == IDX_W'(b))) begin
            rdata = rdata | words[b];
         end
      end
   end

endmodule

// File: rtl/ipc_mailbox_bank.sv
module ipc_mailbox_bank
   import mbx_pkg::*;
#(
   parameter int unsigned NUM_CORES      = 4,
   parameter int unsigned BOXES_PER_CORE = 4,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned SET_BASE       = 32'h80,
   parameter int unsigned CLR_BASE       = 32'hC0,
   parameter bit          FLAG_FROM_NEXT = 1'b0,
   localparam int unsigned NUM_BOXES     = NUM_CORES * BOXES_PER_CORE
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_we,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   output logic [NUM_BOXES-1:0] mbx_pending
);

   localparam int unsigned IDX_W     = (NUM_BOXES > 1) ? $clog2(NUM_BOXES) : 1;
   localparam int unsigned WIN_BYTES = NUM_BOXES * WORD_BYTES;

   // Elaboration-time parameter checks
   generate
      if (NUM_BOXES < 2) begin : g_bad_count
         $error("mailbox bank needs at least two mailboxes");
      end
      if ((SET_BASE % WORD_BYTES) != 0 || (CLR_BASE % WORD_BYTES) != 0) begin : g_bad_align
         $error("window bases must be word aligned");
      end
      if ((SET_BASE + WIN_BYTES > CLR_BASE) && (CLR_BASE + WIN_BYTES > SET_BASE)) begin : g_bad_overlap
         $error("set and clear windows overlap");
      end
      if ((SET_BASE + WIN_BYTES > (1 << ADDR_W)) || (CLR_BASE + WIN_BYTES > (1 << ADDR_W))) begin : g_bad_span
         $error("a window does not fit in the address space");
      end
   endgenerate

   mbx_win_e                         acc_win;
   logic [IDX_W-1:0]                 acc_idx;
   logic [NUM_BOXES-1:0][DATA_W-1:0] box_words;

   mbx_win_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_BOXES(NUM_BOXES),
      .SET_BASE (SET_BASE),
      .CLR_BASE (CLR_BASE)
   ) u_decode (
      .addr(reg_addr),
      .win (acc_win),
      .idx (acc_idx)
   );

   generate
      for (genvar g = 0; g < NUM_BOXES; g++) begin : g_box
         logic hit;
         assign hit = reg_we && (acc_idx == IDX_W'(g));

         mbx_word #(
            .DATA_W        (DATA_W),
            .FLAG_FROM_NEXT(FLAG_FROM_NEXT)
         ) u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_stb(hit && (acc_win == WIN_SET)),
            .clr_stb(hit && (acc_win == WIN_CLR)),
            .wdata  (reg_wdata),
            .word_q (box_words[g]),
            .pend   (mbx_pending[g])
         );
      end
   endgenerate

   mbx_read_sel #(
      .DATA_W   (DATA_W),
      .NUM_BOXES(NUM_BOXES)
   ) u_rsel (
      .words(box_words),
      .win  (acc_win),
      .idx  (acc_idx),
      .rdata(reg_rdata)
   );

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_BOXES = 16,
   parameter int unsigned SET_BASE  = 32'h80,
   parameter int unsigned CLR_BASE  = 32'hC0,
   localparam int unsigned IDX_W    = (NUM_BOXES > 1) ? $clog2(NUM_BOXES) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 reg_we,
   input logic [DATA_W-1:0]    reg_wdata,
   input logic [DATA_W-1:0]    reg_rdata,
   input logic [NUM_BOXES-1:0] mbx_pending
);

   int unsigned      c_byte;
   logic             c_set;
   logic             c_clr;
   logic [IDX_W-1:0] c_idx;

   assign c_byte = 32'(reg_addr) & ~32'd3;
   assign c_set  = (c_byte >= SET_BASE) && (c_byte < SET_BASE + 4 * NUM_BOXES);
   assign c_clr  = (c_byte >= CLR_BASE) && (c_byte < CLR_BASE + 4 * NUM_BOXES);
   assign c_idx  = c_set ? IDX_W'((c_byte - SET_BASE) >> 2) : IDX_W'((c_byte - CLR_BASE) >> 2);

   // R7
   rst_clears_flags_chk: assert property (@(posedge clk)
      !rst_n |=> (mbx_pending == '0));

   // R2
   set_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && c_set && (reg_wdata != '0)) |=> mbx_pending[$past(c_idx)]);

   // R3
   full_clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && c_clr && (&reg_wdata)) |=> !mbx_pending[$past(c_idx)]);

   // R5
   set_window_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_set |-> (reg_rdata == '0));

   // R6
   read_matches_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_clr |-> ((reg_rdata != '0) == mbx_pending[c_idx]));

   // R8
   outside_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !c_set && !c_clr) |=> $stable(mbx_pending));

   // R9
   idle_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> $stable(mbx_pending));

endmodule

bind ipc_mailbox_bank mbx_bank_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_BOXES(NUM_BOXES),
   .SET_BASE (SET_BASE),
   .CLR_BASE (CLR_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_we     (reg_we),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .mbx_pending(mbx_pending)
);

// File: tb/ipc_mailbox_bank_tb_top.sv
module ipc_mailbox_bank_tb_top;

   localparam int NB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NB-1:0] mbx_pending;

   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic [31:0] shadow [NB];

   always #4 clk = ~clk;   // 125 MHz

   ipc_mailbox_bank dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .mbx_pending(mbx_pending)
   );

   function automatic logic [NB-1:0] exp_flags();
      logic [NB-1:0] f;
      for (int i = 0; i < NB; i++) f[i] = (shadow[i] != 0);
      return f;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
      #1;
      if (a >= 8'h80 && a < 8'hC0) shadow[(a - 8'h80) >> 2] |= d;
      else if (a >= 8'hC0) shadow[(a - 8'hC0) >> 2] &= ~d;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R7 flags after reset", 32'(mbx_pending), 32'h0);
      for (int i = 0; i < NB; i++) begin
         bus_read(8'(8'hC0 + 4 * i), d);
         check("R7 word after reset", d, 32'h0);
      end
   endtask

   task automatic t_set_or();
      logic [31:0] d;
      bus_write(8'h94, 32'h0000_00F0);
      bus_write(8'h94, 32'h0000_0F3C);
      bus_read(8'hD4, d);
      check("R2 OR accumulate", d, 32'h0000_0FFC);
      check("R4 read mailbox 5", d, shadow[5]);
      check("R6 flag 5 set", 32'(mbx_pending), 32'h0000_0020);
   endtask

   task automatic t_partial_clear();
      logic [31:0] d;
      bus_write(8'hD4, 32'h0000_000F);
      bus_read(8'hD4, d);
      check("R3 partial clear", d, 32'h0000_0FF0);
      check("R6 flag held with bits left", 32'(mbx_pending), 32'h0000_0020);
      bus_write(8'hD4, 32'h0000_0FF0);
      bus_read(8'hD4, d);
      check("R3 last bits cleared", d, 32'h0);
      check("R6 flag drops at zero", 32'(mbx_pending), 32'h0);
   endtask

   task automatic t_index_map();
      logic [31:0] d;
      for (int i = 0; i < NB; i++) bus_write(8'(8'h80 + 4 * i), 32'(i + 1) * 32'h0101_0011);
      check("R1 all flags", 32'(mbx_pending), 32'(exp_flags()));
      for (int i = 0; i < NB; i++) begin
         bus_read(8'(8'hC0 + 4 * i), d);
         check("R1 word at index", d, shadow[i]);
      end
      for (int i = 0; i < NB; i++) begin
         bus_write(8'(8'hC0 + 4 * ((i * 5) % NB)), 32'hFFFF_FFFF);
         check("R1 flag order while emptying", 32'(mbx_pending), 32'(exp_flags()));
      end
   endtask

   task automatic t_set_window_read();
      logic [31:0] d;
      bus_write(8'h80, 32'hA5A5_0001);
      bus_write(8'hBC, 32'h8000_0000);
      bus_read(8'h80, d);
      check("R5 set window read box 0", d, 32'h0);
      bus_read(8'hBE, d);
      check("R5 set window read box 15", d, 32'h0);
      bus_read(8'hFF, d);
      check("R4 low address bits ignored", d, 32'h8000_0000);
   endtask

   task automatic t_outside();
      logic [31:0] d;
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_write(8'h40, 32'hFFFF_FFFF);
      bus_write(8'h7C, 32'hFFFF_FFFF);
      check("R8 flags after stray writes", 32'(mbx_pending), 32'h0000_8001);
      bus_read(8'h10, d);
      check("R8 outside read", d, 32'h0);
      bus_read(8'hC0, d);
      check("R8 box 0 untouched", d, 32'hA5A5_0001);
   endtask

   task automatic t_timing();
      logic [31:0] d;
      @(negedge clk);
      reg_addr = 8'h88; reg_wdata = 32'h0000_0100; reg_we = 1'b1;
      #3;
      check("R9 flag before edge", 32'(mbx_pending), 32'h0000_8001);
      @(negedge clk);
      reg_we = 1'b0;
      #1;
      shadow[2] |= 32'h0000_0100;
      check("R9 flag after edge", 32'(mbx_pending), 32'h0000_8005);
      reg_addr = 8'hC8; reg_wdata = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      #1;
      bus_read(8'hC8, d);
      check("R9 no change without strobe", d, 32'h0000_0100);
   endtask

   task automatic t_reset_mid();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < NB; i++) shadow[i] = '0;
      check("R7 reset clears live flags", 32'(mbx_pending), 32'h0);
      rst_n = 1'b1;
   endtask

   initial begin
      for (int i = 0; i < NB; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_or();
      t_partial_clear();
      t_index_map();
      t_set_window_read();
      t_outside();
      t_timing();
      t_reset_mid();
      t_reset();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule